// File: doc/BRIEF.md
# Hardware Page-Table Walker (single level)

This block resolves a translation miss without software involvement. When the translation cache reports a miss, the walker takes the missing virtual page number together with the table base of the running process. It forms the address of the table entry and fetches that one 32-bit entry from memory through a request/response handshake. It then decodes the entry. A valid entry becomes a fill for the translation cache, carrying the page number, the physical frame number and the read, write and supervisor permissions. An entry whose valid bit is clear becomes a page-fault pulse instead, and nothing is filled.

Only one walk is in flight at a time. While a walk runs, `busy` is high. The requester treats it as a stall and keeps its miss request pending until the walker is idle again. An ordinary miss never produces a fault: it only costs stall cycles. Each process has its own table, and that table is selected by whichever base value is presented when the miss is accepted.

Top module: `pgwalk_top`

## Requirements
- R1: While `rst_n` is low, and for two clock cycles after it rises, `busy` is 1 and `mem_req_valid`, `fill_valid` and `fault_valid` are 0. After that, with no miss presented, `busy` is 0.
- R2: A miss is accepted on a clock edge where `miss_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle through the cycle of the fill or fault pulse, and 0 in the cycle after that pulse.
- R3: The request address equals `table_base + 4*miss_vpn`, taken modulo 2^PA_W, using the values sampled at acceptance.
- R4: `mem_req_valid` rises in the cycle after acceptance. It holds, with `mem_req_addr` unchanged, until a cycle with `mem_req_ready` high. It then drops, and exactly one request is issued per walk.
- R5: `mem_rsp_valid` is ignored until the request handshake has completed.
- R6: The entry layout is bit 0 valid, bit 1 readable, bit 2 writable, bit 3 supervisor, and bits 31:12 frame number. When the entry has bit 0 equal to 1, `fill_valid` pulses for one cycle, in the cycle after the response. The pulse carries `fill_vpn` equal to the accepted page number, `fill_ppn` equal to bits 31:12, and `fill_rd`, `fill_wr` and `fill_sup` equal to bits 1, 2 and 3. `fault_valid` stays 0.
- R7: When the entry has bit 0 equal to 0, `fault_valid` pulses for one cycle, in the cycle after the response, with `fault_vpn` equal to the accepted page number. `fill_valid` stays 0.
- R8: `miss_valid` and `miss_vpn` presented while `busy` is 1 have no effect on the walk in progress.
- R9: Changes of `table_base` after acceptance have no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Translation miss request |
| miss_vpn | input | VPN_W | Missing virtual page number |
| table_base | input | PA_W | Table base of the current process |
| busy | output | 1 | Walk in progress; requester stalls |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | PTE_W | Returned table entry |
| fill_valid | output | 1 | Translation fill pulse |
| fill_vpn | output | VPN_W | Page number of the fill |
| fill_ppn | output | PTE_W-12 | Frame number of the fill |
| fill_rd | output | 1 | Readable permission |
| fill_wr | output | 1 | Writable permission |
| fill_sup | output | 1 | Supervisor-only permission |
| fault_valid | output | 1 | Page-fault pulse |
| fault_vpn | output | VPN_W | Page number that faulted |

## Verification
The bench stretches the memory handshake by random amounts. If the request were dropped early, or its address moved while `mem_req_ready` was low, the per-cycle hold checks would catch it. During the request phase it injects a stray response carrying the inverted entry, plus a second miss with a fresh base and page number. A walker that sampled data too early, or let a pending miss or base change leak into the walk, would then fill the wrong frame, set the wrong permissions, or report the wrong page. The directed cases cover page number zero, the top page number with a base that makes the address wrap, an all-ones valid entry, and an invalid entry with every other bit set. The last one catches a design that decodes permissions without first looking at the valid bit.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    PW_IDLE  = 3'd0,
    PW_REQ   = 3'd1,
    PW_WAIT  = 3'd2,
    PW_DONE  = 3'd3,
    PW_FAULT = 3'd4
  } pw_state_e;

  // entry field positions
  localparam int unsigned PTE_BIT_V   = 0;
  localparam int unsigned PTE_BIT_R   = 1;
  localparam int unsigned PTE_BIT_W   = 2;
  localparam int unsigned PTE_BIT_S   = 3;
  localparam int unsigned PTE_PPN_LSB = 12;

  typedef struct packed {
    logic rd;
    logic wr;
    logic sup;
  } pw_perm_t;

endpackage

// File: rtl/pgwalk_rst_sync.sv
module pgwalk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PTE_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VPN_W-1:0] vpn_in,
  input  logic [PA_W-1:0]  base_in,
  output logic [VPN_W-1:0] vpn_q,
  output logic [PA_W-1:0]  addr_q
);

  localparam int unsigned IDX_SH = $clog2(PTE_BYTES);
  localparam int unsigned SC_W   = VPN_W + IDX_SH;

  logic [SC_W-1:0] scaled;
  logic [PA_W-1:0] offset;
  logic [PA_W-1:0] addr_d;

  assign scaled = {vpn_in, {IDX_SH{1'b0}}};

  generate
    if (PA_W > SC_W) begin : g_ext
      assign offset = {{(PA_W-SC_W){1'b0}}, scaled};
    end else if (PA_W == SC_W) begin : g_eq
      assign offset = scaled;
    end else begin : g_trunc
      assign offset = scaled[PA_W-1:0];
    end
  endgenerate

  assign addr_d = base_in + offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      addr_q <= '0;
    end else if (load) begin
      vpn_q  <= vpn_in;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic rsp_entry_v,
  output logic load,
  output logic capture,
  output logic req_valid,
  output logic fill_pulse,
  output logic fault_pulse,
  output logic busy
);

  pw_state_e state_q;
  pw_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PW_IDLE:  if (miss_valid)  state_d = PW_REQ;
      PW_REQ:   if (req_ready)   state_d = PW_WAIT;
      PW_WAIT:  if (rsp_valid)   state_d = rsp_entry_v ? PW_DONE : PW_FAULT;
      PW_DONE:                   state_d = PW_IDLE;
      PW_FAULT:                  state_d = PW_IDLE;
      default:                   state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign load        = (state_q == PW_IDLE) && miss_valid;
  assign capture     = (state_q == PW_WAIT) && rsp_valid;
  assign req_valid   = (state_q == PW_REQ);
  assign fill_pulse  = (state_q == PW_DONE);
  assign fault_pulse = (state_q == PW_FAULT);
  assign busy        = (state_q != PW_IDLE);

endmodule

// File: rtl/pgwalk_decode.sv
module pgwalk_decode
  import pgwalk_pkg::*;
#(
  parameter int unsigned PTE_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [PTE_W-1:0]     entry,
  output logic [PTE_W-13:0]    ppn_q,
  output pw_perm_t             perm_q
);

  localparam int unsigned PPN_W = PTE_W - PTE_PPN_LSB;

  logic [PPN_W-1:0] ppn_d;
  pw_perm_t         perm_d;
  logic             pte_unused;

  assign ppn_d      = entry[PTE_W-1:PTE_PPN_LSB];
  assign perm_d.rd  = entry[PTE_BIT_R];
  assign perm_d.wr  = entry[PTE_BIT_W];
  assign perm_d.sup = entry[PTE_BIT_S];
  assign pte_unused = ^{entry[PTE_PPN_LSB-1:PTE_BIT_S+1], entry[PTE_BIT_V]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppn_q  <= '0;
      perm_q <= '0;
    end else if (capture) begin
      ppn_q  <= ppn_d;
      perm_q <= perm_d;
    end
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned PTE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [PA_W-1:0]   table_base,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              fill_valid,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [PTE_W-13:0] fill_ppn,
  output logic              fill_rd,
  output logic              fill_wr,
  output logic              fill_sup,
  output logic              fault_valid,
  output logic [VPN_W-1:0]  fault_vpn
);

  localparam int unsigned PTE_BYTES = PTE_W / 8;

  logic             core_rst_n;
  logic             load;
  logic             capture;
  logic             fsm_busy;
  logic             accept;
  logic [VPN_W-1:0] vpn_q;
  pw_perm_t         perm_q;

  pgwalk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  // no miss is taken while the core is still held in reset
  assign accept = miss_valid && core_rst_n;
  assign busy   = fsm_busy || !core_rst_n;

  pgwalk_fsm u_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .miss_valid  (accept),
    .req_ready   (mem_req_ready),
    .rsp_valid   (mem_rsp_valid),
    .rsp_entry_v (mem_rsp_data[PTE_BIT_V]),
    .load        (load),
    .capture     (capture),
    .req_valid   (mem_req_valid),
    .fill_pulse  (fill_valid),
    .fault_pulse (fault_valid),
    .busy        (fsm_busy)
  );

  pgwalk_addr #(
    .VPN_W     (VPN_W),
    .PA_W      (PA_W),
    .PTE_BYTES (PTE_BYTES)
  ) u_addr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load    (load),
    .vpn_in  (miss_vpn),
    .base_in (table_base),
    .vpn_q   (vpn_q),
    .addr_q  (mem_req_addr)
  );

  pgwalk_decode #(.PTE_W(PTE_W)) u_dec (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .capture (capture),
    .entry   (mem_rsp_data),
    .ppn_q   (fill_ppn),
    .perm_q  (perm_q)
  );

  assign fill_vpn  = vpn_q;
  assign fault_vpn = vpn_q;
  assign fill_rd   = perm_q.rd;
  assign fill_wr   = perm_q.wr;
  assign fill_sup  = perm_q.sup;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned PTE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic [VPN_W-1:0]  miss_vpn,
  input logic [PA_W-1:0]   table_base,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PA_W-1:0]   mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [PTE_W-1:0]  mem_rsp_data,
  input logic              fill_valid,
  input logic [PTE_W-13:0] fill_ppn,
  input logic              fill_rd,
  input logic              fill_wr,
  input logic              fill_sup,
  input logic              fault_valid
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> busy && !mem_req_valid && !fill_valid && !fault_valid); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (miss_valid && !busy) |=> busy); // R2

  AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (fill_valid || fault_valid) |-> busy); // R2

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n) (miss_valid && !busy) |=> (mem_req_valid && (mem_req_addr == PA_W'($past(table_base) + (PA_W'($past(miss_vpn)) << 2))))); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n) (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R4

  AST_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |=> !(fill_valid || fault_valid)); // R5

  AST_FILL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n) fill_valid |-> ($past(mem_rsp_valid) && $past(mem_rsp_data[0]) && (fill_ppn == $past(mem_rsp_data[PTE_W-1:12])) && (fill_rd == $past(mem_rsp_data[1])) && (fill_wr == $past(mem_rsp_data[2])) && (fill_sup == $past(mem_rsp_data[3])))); // R6

  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fill_valid |=> !fill_valid); // R6

  AST_FAULT_SRC: assert property (@(posedge clk) disable iff (!rst_n) fault_valid |-> ($past(mem_rsp_valid) && !$past(mem_rsp_data[0]))); // R7

  AST_FILL_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fill_valid && fault_valid)); // R7

endmodule

bind pgwalk_top pgwalk_chk #(
  .VPN_W (VPN_W),
  .PA_W  (PA_W),
  .PTE_W (PTE_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .miss_vpn      (miss_vpn),
  .table_base    (table_base),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .fill_valid    (fill_valid),
  .fill_ppn      (fill_ppn),
  .fill_rd       (fill_rd),
  .fill_wr       (fill_wr),
  .fill_sup      (fill_sup),
  .fault_valid   (fault_valid)
);

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20;
  localparam int PA_W  = 32;
  localparam int PTE_W = 32;
  localparam int WD_LIMIT = 100000;

  logic              clk;
  logic              rst_n;
  logic              miss_valid;
  logic [VPN_W-1:0]  miss_vpn;
  logic [PA_W-1:0]   table_base;
  logic              busy;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [PA_W-1:0]   mem_req_addr;
  logic              mem_rsp_valid;
  logic [PTE_W-1:0]  mem_rsp_data;
  logic              fill_valid;
  logic [VPN_W-1:0]  fill_vpn;
  logic [PTE_W-13:0] fill_ppn;
  logic              fill_rd;
  logic              fill_wr;
  logic              fill_sup;
  logic              fault_valid;
  logic [VPN_W-1:0]  fault_vpn;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit finished = 0;

  pgwalk_top #(.VPN_W(VPN_W), .PA_W(PA_W), .PTE_W(PTE_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_vpn      (miss_vpn),
    .table_base    (table_base),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .fill_valid    (fill_valid),
    .fill_vpn      (fill_vpn),
    .fill_ppn      (fill_ppn),
    .fill_rd       (fill_rd),
    .fill_wr       (fill_wr),
    .fill_sup      (fill_sup),
    .fault_valid   (fault_valid),
    .fault_vpn     (fault_vpn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [PA_W-1:0] exp_addr(input logic [PA_W-1:0] base, input logic [VPN_W-1:0] vpn);
    return base + {{(PA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [VPN_W-1:0] vpn, input logic [PA_W-1:0] base,
                      input logic [PTE_W-1:0] pte, input int rdy_wait, input int rsp_wait,
                      input bit noise);
    logic [PA_W-1:0] ea;
    ea = exp_addr(base, vpn);
    @(negedge clk);
    miss_valid = 1'b1; miss_vpn = vpn; table_base = base;
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    check(mem_req_valid == 1'b1, "R4 request raised", 64'(mem_req_valid), 64'd1);
    check(mem_req_addr == ea, "R3 entry address", 64'(mem_req_addr), 64'(ea));
    if (noise) begin
      miss_vpn = ~vpn;
      table_base = $urandom;
      mem_rsp_valid = 1'b1;
      mem_rsp_data = ~pte;
    end else begin
      miss_valid = 1'b0;
    end
    for (int i = 0; i < rdy_wait; i++) begin
      @(negedge clk);
      check(mem_req_valid == 1'b1, "R4 request held", 64'(mem_req_valid), 64'd1);
      check(mem_req_addr == ea, noise ? "R9 address held" : "R4 address held", 64'(mem_req_addr), 64'(ea));
    end
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(mem_req_valid == 1'b0, "R4 single request", 64'(mem_req_valid), 64'd0);
    for (int i = 0; i < rsp_wait; i++) begin
      @(negedge clk);
      check(!fill_valid && !fault_valid && busy, "R2 waiting",
            64'({busy, fill_valid, fault_valid}), 64'b100);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data = $urandom;
    if (pte[0]) begin
      check(fill_valid && !fault_valid, "R6 fill pulse", 64'({fill_valid, fault_valid}), 64'b10);
      check(fill_vpn == vpn, noise ? "R8 fill page" : "R6 fill page", 64'(fill_vpn), 64'(vpn));
      check(fill_ppn == pte[31:12], noise ? "R5 fill frame" : "R6 fill frame", 64'(fill_ppn), 64'(pte[31:12]));
      check({fill_rd, fill_wr, fill_sup} == {pte[1], pte[2], pte[3]}, "R6 permissions",
            64'({fill_rd, fill_wr, fill_sup}), 64'({pte[1], pte[2], pte[3]}));
    end else begin
      check(fault_valid && !fill_valid, "R7 fault pulse", 64'({fault_valid, fill_valid}), 64'b10);
      check(fault_vpn == vpn, noise ? "R8 fault page" : "R7 fault page", 64'(fault_vpn), 64'(vpn));
    end
    check(busy == 1'b1, "R2 busy on pulse", 64'(busy), 64'd1);
    @(negedge clk);
    miss_valid = 1'b0;
    check(!busy && !fill_valid && !fault_valid && !mem_req_valid, "R2 back to idle",
          64'({busy, fill_valid, fault_valid, mem_req_valid}), 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT && !finished) begin
        finished = 1;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    rst_n = 1'b0;
    miss_valid = 1'b0; miss_vpn = '0; table_base = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    check(busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 in reset",
          64'({busy, mem_req_valid, fill_valid, fault_valid}), 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R1 release window", 64'(busy), 64'd1);
    repeat (3) @(negedge clk);
    check(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 idle after reset",
          64'({busy, mem_req_valid, fill_valid, fault_valid}), 64'd0);

    // directed corners
    walk(20'h00000, 32'h0001_0000, 32'h0000_3007, 0, 0, 0);
    walk(20'hFFFFF, 32'hFFFF_F000, 32'hABCD_E00B, 2, 1, 0);
    walk(20'h12345, 32'h8000_0000, 32'hFFFF_FFFF, 1, 3, 1);
    walk(20'h00ABC, 32'h0040_0000, 32'hFFFF_FFFE, 3, 0, 1);
    walk(20'h00ABC, 32'h0080_0000, 32'h5555_5003, 0, 2, 0);

    // random walks
    for (int k = 0; k < 60; k++) begin
      logic [PTE_W-1:0] pte;
      pte = $urandom;
      walk(VPN_W'($urandom), $urandom, pte, int'($urandom_range(0, 4)),
           int'($urandom_range(0, 4)), bit'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule